// File: doc/BRIEF.md
# Predicated Vector Element Issue Unroller

This block sits between instruction decode and an issue queue. It takes one decoded scalar instruction at a time. Each instruction carries an opcode and three 5-bit architectural register numbers: a destination and two sources. A 32-entry tag table maps every architectural register to a 7-bit physical register in a 128-entry file. Each entry also marks the register as vectorised or not and gives it an element width. Software writes the table through a configuration port, together with a vector-length register and a 64-bit predicate register.

An instruction whose three registers are all untagged leaves as a single micro-op with its registers redirected. An instruction that touches at least one vectorised register is expanded into element micro-ops, one for each element index below the vector length. Each vectorised operand advances by one physical register per element, while untagged operands stay fixed. Elements whose predicate bit is clear are dropped before issue and cost no output cycle. The survivors leave over a valid/ready handshake. While an instruction is being unrolled, the input side is stalled.

Top module: `vec_issue_unroller`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Every tag entry then maps register n to physical register n, untagged, with width code 0. The vector length is 1 and all predicate bits are 1.
- R2: An accepted instruction with no vectorised operand yields exactly one micro-op. Its register numbers are the table's physical numbers, its element index is 0 and its error bit is 0.
- R3: An accepted instruction with at least one vectorised operand yields element micro-ops in ascending element index. For element e, a vectorised operand carries its base physical number plus e, and an untagged operand carries its base unchanged.
- R4: Predicate bit i governs element i. An element whose bit is 0 produces no micro-op. The surviving elements appear on consecutive output cycles when out_ready stays high.
- R5: A vectorised instruction whose predicate bits are all 0 below the vector length emits nothing, and in_ready is 1 again on the following cycle.
- R6: A vector-length write of 0 is stored as 1 and a write above 64 is stored as 64. No element with index at or above the stored length is ever issued.
- R7: Each operand's width code (0 = 64-bit, 1 = 32-bit, 2 = 16-bit, 3 = 8-bit) appears on out_wd, out_w1 and out_w2 for destination, source 1 and source 2 on every micro-op of the instruction.
- R8: Redirection is unrestricted: two different architectural registers may map to the same physical register, and both then appear with that number.
- R9: When base plus element index exceeds 127 for a vectorised operand, that operand reads 127 and the micro-op's out_err bit is 1. Otherwise out_err is 0.
- R10: While out_valid is 1 and out_ready is 0, every output field holds its value. in_ready is 0 for as long as micro-ops of the current instruction remain.
- R11: Tag, vector-length and predicate writes made while an instruction is being unrolled do not change that instruction's micro-ops. They apply from the next accepted instruction.
- R12: An instruction with no vectorised operand is issued even when predicate bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tag_we | input | 1 | Write one tag entry |
| cfg_tag_reg | input | 5 | Architectural register whose entry is written |
| cfg_tag_vec | input | 1 | Vectorised flag for the entry |
| cfg_tag_base | input | 7 | Physical base register for the entry |
| cfg_tag_width | input | 2 | Element width code for the entry |
| cfg_vl_we | input | 1 | Write the vector length |
| cfg_vl | input | 7 | Requested vector length (clamped to 1..64) |
| cfg_pred_we | input | 1 | Write the predicate mask |
| cfg_pred | input | 64 | Predicate mask, bit i for element i |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept an instruction |
| in_op | input | 8 | Opcode, passed through unchanged |
| in_rd | input | 5 | Destination architectural register |
| in_rs1 | input | 5 | Source 1 architectural register |
| in_rs2 | input | 5 | Source 2 architectural register |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Issue queue takes the micro-op |
| out_op | output | 8 | Opcode of the micro-op |
| out_rd | output | 7 | Destination physical register |
| out_rs1 | output | 7 | Source 1 physical register |
| out_rs2 | output | 7 | Source 2 physical register |
| out_wd | output | 2 | Destination width code |
| out_w1 | output | 2 | Source 1 width code |
| out_w2 | output | 2 | Source 2 width code |
| out_elem | output | 6 | Element index of the micro-op |
| out_err | output | 1 | Physical register number was clamped |

## Verification
The assertions assume that out_ready is a plain input that may drop at any cycle. They also assume that an instruction is offered only through the in_valid/in_ready handshake, so that a new instruction never overlaps the micro-ops of the previous one. The bench drives every input shortly after the rising edge and holds in_valid until in_ready is seen, so each instruction is accepted exactly once. It keeps tag bases and vector lengths inside their port widths. Configuration writes are placed both between instructions and in the middle of an unrolling, to show that the block snapshots its configuration at acceptance.

// File: rtl/vu_pkg.sv
package vu_pkg;

    localparam int ARCH_REGS_D = 32;
    localparam int PHYS_REGS_D = 128;
    localparam int MAX_VL_D    = 64;
    localparam int OP_W_D      = 8;
    localparam int N_OPND      = 3;

    typedef enum logic [1:0] {
        EW_64 = 2'd0,
        EW_32 = 2'd1,
        EW_16 = 2'd2,
        EW_8  = 2'd3
    } elem_width_e;

    // Bring a requested element count into the range 1..maxv.
    function automatic int clamp_len(int req, int maxv);
        if (req < 1)
            return 1;
        else if (req > maxv)
            return maxv;
        else
            return req;
    endfunction

endpackage

// File: rtl/vu_tag_table.sv
module vu_tag_table
    import vu_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int PW      = 7,
    parameter int NRD     = 3,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wvec,
    input  logic [PW-1:0] wbase,
    input  elem_width_e   wew,
    input  logic [AW-1:0] raddr [NRD],
    output logic          rvec  [NRD],
    output logic [PW-1:0] rbase [NRD],
    output elem_width_e   rew   [NRD]
);

    logic          vec_m  [ENTRIES];
    logic [PW-1:0] base_m [ENTRIES];
    elem_width_e   ew_m   [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vec_m[i]  <= 1'b0;
                base_m[i] <= PW'(i);
                ew_m[i]   <= EW_64;
            end
        end else if (we) begin
            vec_m[waddr]  <= wvec;
            base_m[waddr] <= wbase;
            ew_m[waddr]   <= wew;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rvec[g]  = vec_m[raddr[g]];
        assign rbase[g] = base_m[raddr[g]];
        assign rew[g]   = ew_m[raddr[g]];
    end

endmodule

// File: rtl/vu_pred_scan.sv
module vu_pred_scan #(
    parameter int MAXVL = 64,
    parameter int IW    = $clog2(MAXVL)
) (
    input  logic [MAXVL-1:0] mask,
    input  logic [IW:0]      start,
    input  logic [IW:0]      limit,
    output logic             found,
    output logic [IW-1:0]    idx
);

    // Lowest set mask bit in [start, limit); scanned from the top so the
    // last hit written is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = MAXVL - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(start)) && (i < int'(limit))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vu_elem_addr.sv
module vu_elem_addr #(
    parameter int PHYS_REGS = 128,
    parameter int PW        = $clog2(PHYS_REGS),
    parameter int IW        = 6
) (
    input  logic          vec,
    input  logic [PW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [PW-1:0] phys,
    output logic          err
);

    localparam int SW = ((PW > IW) ? PW : IW) + 1;
    localparam logic [SW-1:0] TOP_REG = SW'(PHYS_REGS - 1);

    logic [SW-1:0] sum;

    assign sum  = SW'(base) + (vec ? SW'(idx) : '0);
    assign err  = (sum > TOP_REG);
    assign phys = err ? PW'(TOP_REG) : sum[PW-1:0];

endmodule

// File: rtl/vec_issue_unroller.sv
module vec_issue_unroller
    import vu_pkg::*;
#(
    parameter int ARCH_REGS  = ARCH_REGS_D,
    parameter int PHYS_REGS  = PHYS_REGS_D,
    parameter int MAX_VL     = MAX_VL_D,
    parameter int OP_W       = OP_W_D,
    localparam int AW        = $clog2(ARCH_REGS),
    localparam int PW        = $clog2(PHYS_REGS),
    localparam int IW        = $clog2(MAX_VL),
    localparam int LW        = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_tag_we,
    input  logic [AW-1:0]     cfg_tag_reg,
    input  logic              cfg_tag_vec,
    input  logic [PW-1:0]     cfg_tag_base,
    input  logic [1:0]        cfg_tag_width,
    input  logic              cfg_vl_we,
    input  logic [LW-1:0]     cfg_vl,
    input  logic              cfg_pred_we,
    input  logic [MAX_VL-1:0] cfg_pred,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [AW-1:0]     in_rd,
    input  logic [AW-1:0]     in_rs1,
    input  logic [AW-1:0]     in_rs2,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OP_W-1:0]   out_op,
    output logic [PW-1:0]     out_rd,
    output logic [PW-1:0]     out_rs1,
    output logic [PW-1:0]     out_rs2,
    output logic [1:0]        out_wd,
    output logic [1:0]        out_w1,
    output logic [1:0]        out_w2,
    output logic [IW-1:0]     out_elem,
    output logic              out_err
);

    typedef struct packed {
        logic          vec;
        logic [PW-1:0] base;
        elem_width_e   ew;
    } opnd_tag_t;

    // ---------------- configuration registers ----------------
    logic [LW-1:0]     vl_reg;
    logic [MAX_VL-1:0] pred_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_reg   <= LW'(1);
            pred_reg <= '1;
        end else begin
            if (cfg_vl_we)
                vl_reg <= LW'(clamp_len(int'(cfg_vl), MAX_VL));
            if (cfg_pred_we)
                pred_reg <= cfg_pred;
        end
    end

    // ---------------- tag lookup ----------------
    logic [AW-1:0] lk_addr [N_OPND];
    logic          lk_vec  [N_OPND];
    logic [PW-1:0] lk_base [N_OPND];
    elem_width_e   lk_ew   [N_OPND];

    assign lk_addr[0] = in_rd;
    assign lk_addr[1] = in_rs1;
    assign lk_addr[2] = in_rs2;

    vu_tag_table #(
        .ENTRIES (ARCH_REGS),
        .PW      (PW),
        .NRD     (N_OPND)
    ) u_tags (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_tag_we),
        .waddr (cfg_tag_reg),
        .wvec  (cfg_tag_vec),
        .wbase (cfg_tag_base),
        .wew   (elem_width_e'(cfg_tag_width)),
        .raddr (lk_addr),
        .rvec  (lk_vec),
        .rbase (lk_base),
        .rew   (lk_ew)
    );

    logic any_vec;
    assign any_vec = lk_vec[0] | lk_vec[1] | lk_vec[2];

    // ---------------- instruction snapshot ----------------
    logic              busy_q;
    logic              vec_q;
    logic [OP_W-1:0]   op_q;
    opnd_tag_t         tag_q [N_OPND];
    logic [MAX_VL-1:0] pred_q;
    logic [LW-1:0]     vl_q;
    logic [IW-1:0]     idx_q;

    logic          accept;
    logic          fire;
    logic          first_found;
    logic [IW-1:0] first_idx;
    logic          next_found;
    logic [IW-1:0] next_idx;

    assign in_ready  = !busy_q;
    assign out_valid = busy_q;
    assign accept    = in_valid && in_ready;
    assign fire      = out_valid && out_ready;

    // first surviving element of a newly offered instruction
    vu_pred_scan #(.MAXVL(MAX_VL)) u_scan_first (
        .mask  (pred_reg),
        .start ('0),
        .limit (vl_reg),
        .found (first_found),
        .idx   (first_idx)
    );

    // next surviving element after the one on the output
    vu_pred_scan #(.MAXVL(MAX_VL)) u_scan_next (
        .mask  (pred_q),
        .start (LW'(idx_q) + LW'(1)),
        .limit (vl_q),
        .found (next_found),
        .idx   (next_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            vec_q  <= 1'b0;
            op_q   <= '0;
            pred_q <= '0;
            vl_q   <= LW'(1);
            idx_q  <= '0;
            for (int k = 0; k < N_OPND; k++)
                tag_q[k] <= '{vec: 1'b0, base: '0, ew: EW_64};
        end else if (accept) begin
            vec_q  <= any_vec;
            op_q   <= in_op;
            pred_q <= pred_reg;
            vl_q   <= vl_reg;
            for (int k = 0; k < N_OPND; k++)
                tag_q[k] <= '{vec: lk_vec[k], base: lk_base[k], ew: lk_ew[k]};
            if (any_vec) begin
                busy_q <= first_found;
                idx_q  <= first_idx;
            end else begin
                busy_q <= 1'b1;
                idx_q  <= '0;
            end
        end else if (fire) begin
            if (vec_q && next_found)
                idx_q <= next_idx;
            else
                busy_q <= 1'b0;
        end
    end

    // ---------------- per-operand element addressing ----------------
    logic [PW-1:0] el_phys [N_OPND];
    logic          el_err  [N_OPND];

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        vu_elem_addr #(
            .PHYS_REGS (PHYS_REGS),
            .PW        (PW),
            .IW        (IW)
        ) u_addr (
            .vec  (tag_q[g].vec),
            .base (tag_q[g].base),
            .idx  (idx_q),
            .phys (el_phys[g]),
            .err  (el_err[g])
        );
    end

    assign out_op   = op_q;
    assign out_rd   = el_phys[0];
    assign out_rs1  = el_phys[1];
    assign out_rs2  = el_phys[2];
    assign out_wd   = tag_q[0].ew;
    assign out_w1   = tag_q[1].ew;
    assign out_w2   = tag_q[2].ew;
    assign out_elem = idx_q;
    assign out_err  = el_err[0] | el_err[1] | el_err[2];

    // ---------------- assertions ----------------
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd)
            && $stable(out_rs1) && $stable(out_rs2) && $stable(out_elem)
            && $stable(out_wd) && $stable(out_w1) && $stable(out_w2) && $stable(out_err)));

    assert_elem_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid || (out_elem > $past(out_elem))));

    assert_pred_bit_set_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && vec_q) |-> pred_q[out_elem]);

    assert_below_length_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (LW'(out_elem) < vl_q));

    assert_length_range_R6: assert property (@(posedge clk) disable iff (rst)
        (vl_reg >= LW'(1)) && (vl_reg <= LW'(MAX_VL)));

    assert_clamp_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> ((out_rd == PW'(PHYS_REGS - 1))
            || (out_rs1 == PW'(PHYS_REGS - 1)) || (out_rs2 == PW'(PHYS_REGS - 1))));

    assert_scalar_single_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !vec_q) |=> !out_valid);

endmodule

// File: tb/sim_vec_issue_unroller.sv
module sim_vec_issue_unroller;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_tag_we = 1'b0;
    logic [4:0]  cfg_tag_reg = '0;
    logic        cfg_tag_vec = 1'b0;
    logic [6:0]  cfg_tag_base = '0;
    logic [1:0]  cfg_tag_width = '0;
    logic        cfg_vl_we = 1'b0;
    logic [6:0]  cfg_vl = '0;
    logic        cfg_pred_we = 1'b0;
    logic [63:0] cfg_pred = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_op = '0;
    logic [4:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_op;
    logic [6:0]  out_rd, out_rs1, out_rs2;
    logic [1:0]  out_wd, out_w1, out_w2;
    logic [5:0]  out_elem;
    logic        out_err;

    always #10 clk = ~clk;

    vec_issue_unroller u0 (
        .clk(clk), .rst(rst),
        .cfg_tag_we(cfg_tag_we), .cfg_tag_reg(cfg_tag_reg), .cfg_tag_vec(cfg_tag_vec),
        .cfg_tag_base(cfg_tag_base), .cfg_tag_width(cfg_tag_width),
        .cfg_vl_we(cfg_vl_we), .cfg_vl(cfg_vl),
        .cfg_pred_we(cfg_pred_we), .cfg_pred(cfg_pred),
        .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
        .out_wd(out_wd), .out_w1(out_w1), .out_w2(out_w2),
        .out_elem(out_elem), .out_err(out_err)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;
    int    cyc = 0;
    int    ready_mode = 0;

    // reference model state
    bit          m_vec  [32];
    int          m_base [32];
    int          m_ew   [32];
    int          m_vl;
    logic [63:0] m_pred;
    logic [46:0] exp_q [$];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [46:0] make_uop(int op, int r0, int r1, int r2, int e);
        int  rr [3];
        int  p  [3];
        bit  err;
        rr[0] = r0; rr[1] = r1; rr[2] = r2;
        err = 1'b0;
        for (int k = 0; k < 3; k++) begin
            p[k] = m_base[rr[k]] + (m_vec[rr[k]] ? e : 0);
            if (p[k] > 127) begin
                p[k] = 127;
                err  = 1'b1;
            end
        end
        return {8'(op), 7'(p[0]), 7'(p[1]), 7'(p[2]),
                2'(m_ew[r0]), 2'(m_ew[r1]), 2'(m_ew[r2]), 6'(e), err};
    endfunction

    task automatic model_accept(int op, int r0, int r1, int r2);
        if (!(m_vec[r0] || m_vec[r1] || m_vec[r2]))
            exp_q.push_back(make_uop(op, r0, r1, r2, 0));
        else
            for (int e = 0; e < m_vl; e++)
                if (m_pred[e])
                    exp_q.push_back(make_uop(op, r0, r1, r2, e));
    endtask

    // compared on every clock, mid-cycle
    always @(negedge clk) begin
        if (started && !rst) begin
            logic [46:0] got;
            chk(out_valid == (exp_q.size() != 0), cur_req, "out_valid", out_valid, exp_q.size() != 0);
            chk(in_ready == (exp_q.size() == 0), cur_req, "in_ready", in_ready, exp_q.size() == 0);
            if (out_valid && out_ready) begin
                got = {out_op, out_rd, out_rs1, out_rs2, out_wd, out_w1, out_w2, out_elem, out_err};
                if (exp_q.size() == 0)
                    chk(1'b0, cur_req, "unexpected micro-op", got, 0);
                else begin
                    chk(got == exp_q[0], cur_req, "micro-op", got, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            if (in_valid && in_ready)
                model_accept(in_op, in_rd, in_rs1, in_rs2);
            if (cfg_tag_we) begin
                m_vec[cfg_tag_reg]  = cfg_tag_vec;
                m_base[cfg_tag_reg] = cfg_tag_base;
                m_ew[cfg_tag_reg]   = cfg_tag_width;
            end
            if (cfg_vl_we)
                m_vl = (cfg_vl == 0) ? 1 : ((cfg_vl > 64) ? 64 : int'(cfg_vl));
            if (cfg_pred_we)
                m_pred = cfg_pred;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    task automatic set_tag(int r, bit v, int b, int w);
        cfg_tag_we = 1'b1; cfg_tag_reg = 5'(r); cfg_tag_vec = v;
        cfg_tag_base = 7'(b); cfg_tag_width = 2'(w);
        @(posedge clk); #2;
        cfg_tag_we = 1'b0;
    endtask

    task automatic set_vl(int v);
        cfg_vl_we = 1'b1; cfg_vl = 7'(v);
        @(posedge clk); #2;
        cfg_vl_we = 1'b0;
    endtask

    task automatic set_pred(logic [63:0] p);
        cfg_pred_we = 1'b1; cfg_pred = p;
        @(posedge clk); #2;
        cfg_pred_we = 1'b0;
    endtask

    task automatic send(int op, int r0, int r1, int r2);
        bit taken;
        in_valid = 1'b1; in_op = 8'(op);
        in_rd = 5'(r0); in_rs1 = 5'(r1); in_rs2 = 5'(r2);
        taken = 1'b0;
        for (int t = 0; t < 2000 && !taken; t++) begin
            @(negedge clk);
            taken = in_ready;
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        bit idle;
        idle = 1'b0;
        for (int t = 0; t < 2000 && !idle; t++) begin
            @(negedge clk);
            idle = (exp_q.size() == 0) && in_ready;
        end
        @(posedge clk); #2;
        chk(exp_q.size() == 0, cur_req, "pending micro-ops", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired in %s", cur_req);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_vec[i] = 1'b0; m_base[i] = i; m_ew[i] = 0;
        end
        m_vl = 1;
        m_pred = '1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        @(posedge clk); #2;
        started = 1'b1;

        // R1: identity mapping, untagged, width 64
        cur_req = "R1";
        send(8'h11, 3, 17, 31);
        wait_idle();

        // R2: untagged instruction with redirection
        cur_req = "R2";
        set_tag(3, 0, 40, 1);
        set_tag(7, 0, 7, 3);
        send(8'h22, 3, 7, 0);
        wait_idle();

        // R3: vectorised destination and source 2, scalar source 1
        cur_req = "R3";
        set_vl(5);
        set_tag(4, 1, 10, 2);
        send(8'h33, 4, 5, 4);
        wait_idle();

        // R4: sparse predicate, survivors back to back
        cur_req = "R4";
        set_vl(8);
        set_pred(64'h0000_0000_0000_00A5);
        send(8'h44, 4, 4, 1);
        wait_idle();

        // R5: every bit below the length clear
        cur_req = "R5";
        set_pred(64'h0000_0000_0000_FF00);
        send(8'h55, 4, 2, 3);
        @(negedge clk);
        chk(in_ready && !out_valid, "R5", "idle after empty unroll", {in_ready, out_valid}, 2'b10);
        @(posedge clk); #2;
        wait_idle();

        // R6: length clamps
        cur_req = "R6";
        set_pred('1);
        set_vl(0);
        send(8'h66, 4, 0, 0);
        wait_idle();
        set_tag(4, 1, 0, 0);
        set_vl(100);
        send(8'h67, 4, 4, 4);
        wait_idle();

        // R7: all four width codes
        cur_req = "R7";
        set_vl(3);
        set_tag(12, 1, 20, 0);
        set_tag(13, 0, 50, 2);
        set_tag(14, 1, 60, 3);
        send(8'h77, 12, 13, 14);
        wait_idle();
        set_tag(13, 1, 51, 1);
        send(8'h78, 13, 14, 12);
        wait_idle();

        // R8: two registers onto the same physical register
        cur_req = "R8";
        set_tag(9, 0, 112, 1);
        set_tag(10, 0, 112, 2);
        send(8'h88, 9, 10, 9);
        wait_idle();

        // R9: overflow past the top register
        cur_req = "R9";
        set_vl(6);
        set_tag(15, 1, 125, 0);
        send(8'h99, 15, 9, 15);
        wait_idle();

        // R10: stalls from the issue queue
        cur_req = "R10";
        ready_mode = 1;
        set_vl(9);
        set_pred(64'h0000_0000_0000_01DB);
        send(8'hA0, 12, 15, 10);
        wait_idle();

        // R11: configuration changes while unrolling
        cur_req = "R11";
        set_vl(10);
        set_pred('1);
        send(8'hB0, 4, 12, 3);
        set_tag(4, 1, 90, 3);
        set_vl(2);
        set_pred(64'h2);
        wait_idle();
        send(8'hB1, 4, 12, 3);
        wait_idle();
        ready_mode = 0;

        // R12: scalar ignores predicate
        cur_req = "R12";
        set_pred(64'h0);
        send(8'hC0, 0, 1, 2);
        wait_idle();

        // mixed traffic against the model
        cur_req = "R3";
        for (int n = 0; n < 30; n++) begin
            ready_mode = n % 2;
            set_tag($urandom_range(0, 31), 1'($urandom_range(0, 1)),
                    $urandom_range(0, 127), $urandom_range(0, 3));
            if (n % 4 == 0) set_vl($urandom_range(0, 127));
            if (n % 3 == 0) set_pred({$urandom, $urandom});
            send($urandom_range(0, 255), $urandom_range(0, 31),
                 $urandom_range(0, 31), $urandom_range(0, 31));
            wait_idle();
        end

        finish_run();
    end

endmodule